// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register set is organised as overlapping windows. Software names a register with a 5-bit number. The upper two bits choose one of four 8-register frames: globals, outs, locals or ins. The lower three bits choose the register inside that frame. A current-window pointer decides which physical segments back the three windowed frames. The segment arithmetic makes the ins of one window the same storage as the outs of the next window, so a caller and its callee can exchange arguments without copying them.

The globals are kept in several separate banks, and a global-level input picks the bank in use. The block has two combinational read ports and one write port that updates storage on the clock edge. Read port A also reports the flattened physical index that its register number maps to. A one-cycle clear input zeroes every bank and every segment. The window pointer and the global level are captured in registers, so each change takes effect on the following cycle.

Top module: `winreg_file`

## Requirements
- R1: In the globals frame (bits [4:3] = 0), the flattened index is the captured global level times 8, ORed with bits [2:0] of the register number.
- R2: With captured pointer c and base segment s = ((NWIN - c) mod NWIN) * 2, the outs frame (bits [4:3] = 1) maps to segment s, the locals frame (= 2) to s+1 and the ins frame (= 3) to (s+2) mod (2*NWIN). The flattened index of segment k is NGLB*8 + k*8, ORed with the offset.
- R3: A value written to an out register under pointer c reads back from the in register with the same offset under pointer (c+1) mod NWIN.
- R4: Each global bank is separate storage. A write under one global level does not change the same register under another level.
- R5: Register number 0 always reads as zero, and writes to it are discarded.
- R6: The two read ports work independently, and both return data in the same cycle as their addresses.
- R7: When a read and a write hit the same physical register in one cycle, the read returns the value held before the write.
- R8: New window-pointer and global-level values are used from the cycle after they are presented. Reads and writes in the cycle where they are presented still use the previous mapping.
- R9: A global-level value of NGLB or more, or a window-pointer value of NWIN or more, is ignored and the previous setting is kept.
- R10: The clear input zeroes every global bank and every windowed segment. A write in the same cycle as a clear is dropped.
- R11: After a synchronous reset, the pointer and the global level are both 0 and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zeroes all register storage at the next edge |
| cwp_in | input | $clog2(NWIN) | Requested current-window pointer |
| gl_in | input | $clog2(NGLB) | Requested global level |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| rd_a_addr | input | 5 | Register number for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_a_flat | output | IDXW | Flattened physical index for read port A |
| rd_b_addr | input | 5 | Register number for read port B |
| rd_b_data | output | XLEN | Read port B data |

## Verification
Read data and the flattened index are combinational, so they are due in the same cycle their address is driven. Writes, clears, pointer changes and level changes become visible one edge later. The bench drives every input just after the falling edge and computes the expected values from a model whose mapping is updated only once that cycle's edge has passed. The monitor compares the outputs two nanoseconds after the same falling edge, well before the next rising edge. This makes the old-mapping and read-before-write cases fall on exactly the cycle in which their stimulus is applied.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int SLOT_BITS = 3;
  localparam int SLOTS     = 1 << SLOT_BITS;

  typedef enum logic [1:0] {
    FR_GLB = 2'd0,
    FR_OUT = 2'd1,
    FR_LOC = 2'd2,
    FR_INS = 2'd3
  } frame_e;
endpackage

// File: rtl/winreg_ctx.sv
module winreg_ctx #(
  parameter int NWIN = 8,
  parameter int NGLB = 3,
  parameter int CWPW = 3,
  parameter int GLW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CWPW-1:0] cwp_in,
  input  logic [GLW-1:0]  gl_in,
  output logic [CWPW-1:0] cwp_q,
  output logic [GLW-1:0]  gl_q
);
  localparam logic [CWPW:0] NWIN_L = NWIN[CWPW:0];
  localparam logic [GLW:0]  NGLB_L = NGLB[GLW:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      gl_q  <= '0;
    end else begin
      if ({1'b0, cwp_in} < NWIN_L) cwp_q <= cwp_in;
      if ({1'b0, gl_in}  < NGLB_L) gl_q  <= gl_in;
    end
  end
endmodule

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGLB = 3,
  parameter int CWPW = 3,
  parameter int GLW  = 2,
  parameter int IDXW = 8
) (
  input  logic [4:0]      addr,
  input  logic [CWPW-1:0] cwp,
  input  logic [GLW-1:0]  gl,
  output logic [IDXW-1:0] flat
);
  localparam int GBASE = NGLB * SLOTS;
  localparam int NSEG  = 2 * NWIN;

  int seg0;
  int base;
  int phys;

  always_comb begin
    seg0 = ((NWIN - int'(cwp)) % NWIN) * 2;
    case (frame_e'(addr[4:3]))
      FR_GLB:  base = int'(gl) * SLOTS;
      FR_OUT:  base = GBASE + seg0 * SLOTS;
      FR_LOC:  base = GBASE + (seg0 + 1) * SLOTS;
      default: base = GBASE + ((seg0 + 2) % NSEG) * SLOTS;
    endcase
    phys = base | int'(addr[SLOT_BITS-1:0]);
    flat = phys[IDXW-1:0];
  end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 152,
  parameter int IDXW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [IDXW-1:0] ra,
  input  logic [IDXW-1:0] rb,
  output logic [XLEN-1:0] rda,
  output logic [XLEN-1:0] rdb
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rda = mem[ra];
  assign rdb = mem[rb];
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGLB = 3,
  parameter int XLEN = 32,
  localparam int CWPW  = $clog2(NWIN),
  localparam int GLW   = $clog2(NGLB),
  localparam int DEPTH = (NGLB + 2 * NWIN) * SLOTS,
  localparam int IDXW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [CWPW-1:0] cwp_in,
  input  logic [GLW-1:0]  gl_in,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [4:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  output logic [IDXW-1:0] rd_a_flat,
  input  logic [4:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data
);
  localparam int NPORT = 3;

  logic [CWPW-1:0] cwp_q;
  logic [GLW-1:0]  gl_q;
  logic [4:0]      port_addr [NPORT];
  logic [IDXW-1:0] port_flat [NPORT];
  logic [XLEN-1:0] raw_a, raw_b;
  logic            wr_live;

  winreg_ctx #(.NWIN(NWIN), .NGLB(NGLB), .CWPW(CWPW), .GLW(GLW)) u_ctx (
    .clk(clk), .rst(rst), .cwp_in(cwp_in), .gl_in(gl_in),
    .cwp_q(cwp_q), .gl_q(gl_q)
  );

  assign port_addr[0] = rd_a_addr;
  assign port_addr[1] = rd_b_addr;
  assign port_addr[2] = wr_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_map #(
      .NWIN(NWIN), .NGLB(NGLB), .CWPW(CWPW), .GLW(GLW), .IDXW(IDXW)
    ) u_map (
      .addr(port_addr[p]), .cwp(cwp_q), .gl(gl_q), .flat(port_flat[p])
    );
  end

  assign wr_live = wr_en && (wr_addr != 5'd0);

  winreg_store #(.XLEN(XLEN), .DEPTH(DEPTH), .IDXW(IDXW)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .we(wr_live),
    .waddr(port_flat[2]), .wdata(wr_data),
    .ra(port_flat[0]), .rb(port_flat[1]),
    .rda(raw_a), .rdb(raw_b)
  );

  assign rd_a_data = (rd_a_addr == 5'd0) ? '0 : raw_a;
  assign rd_b_data = (rd_b_addr == 5'd0) ? '0 : raw_b;
  assign rd_a_flat = port_flat[0];
endmodule

module winreg_file_chk #(
  parameter int NWIN = 8,
  parameter int NGLB = 3,
  parameter int XLEN = 32,
  parameter int CWPW = 3,
  parameter int GLW  = 2,
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            clr,
  input logic [CWPW-1:0] cwp_in,
  input logic [GLW-1:0]  gl_in,
  input logic [CWPW-1:0] cwp_q,
  input logic [GLW-1:0]  gl_q,
  input logic [4:0]      rd_a_addr,
  input logic [XLEN-1:0] rd_a_data,
  input logic [IDXW-1:0] rd_a_flat
);
  localparam logic [CWPW:0] NWIN_L = NWIN[CWPW:0];
  localparam logic [GLW:0]  NGLB_L = NGLB[GLW:0];
  localparam int GBASE = NGLB * 8;
  localparam int DEPTH = (NGLB + 2 * NWIN) * 8;

  // R1: a globals-frame register lands in the bank chosen by the captured level
  a_r1_global_flat: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr[4:3] == 2'b00) |->
      (int'(rd_a_flat) == int'(gl_q) * 8 + int'(rd_a_addr[2:0])));

  // R2: a windowed register lands above the global banks, inside storage
  a_r2_window_range: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr[4:3] != 2'b00) |->
      (int'(rd_a_flat) >= GBASE && int'(rd_a_flat) < DEPTH));

  // R5: register number 0 reads zero
  a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

  // R8: a legal pointer is in use from the next cycle
  a_r8_cwp_next: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cwp_in} < NWIN_L) |=> (cwp_q == $past(cwp_in)));

  // R9: an out-of-range global level leaves the level unchanged
  a_r9_gl_hold: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, gl_in} >= NGLB_L) |=> $stable(gl_q));

  // R10: everything reads zero in the cycle after a clear
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rd_a_data == '0));

  // R11: the mapping state starts from zero after reset
  a_r11_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cwp_q == '0 && gl_q == '0));
endmodule

bind winreg_file winreg_file_chk #(
  .NWIN(NWIN), .NGLB(NGLB), .XLEN(XLEN), .CWPW(CWPW), .GLW(GLW), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .cwp_in(cwp_in), .gl_in(gl_in),
  .cwp_q(cwp_q), .gl_q(gl_q), .rd_a_addr(rd_a_addr),
  .rd_a_data(rd_a_data), .rd_a_flat(rd_a_flat)
);

// File: tb/winreg_file_bench.sv
`timescale 1ns/1ps
module winreg_file_bench;
  localparam int NWIN  = 8;
  localparam int NGLB  = 3;
  localparam int XLEN  = 32;
  localparam int DEPTH = (NGLB + 2 * NWIN) * 8;
  localparam int IDXW  = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            clr = 1'b0;
  logic [2:0]      cwp_in = '0;
  logic [1:0]      gl_in = '0;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [4:0]      rd_a_addr = '0;
  logic [XLEN-1:0] rd_a_data;
  logic [IDXW-1:0] rd_a_flat;
  logic [4:0]      rd_b_addr = '0;
  logic [XLEN-1:0] rd_b_data;

  always #4 clk = ~clk;

  winreg_file #(.NWIN(NWIN), .NGLB(NGLB), .XLEN(XLEN)) u_winreg_file (
    .clk(clk), .rst(rst), .clr(clr), .cwp_in(cwp_in), .gl_in(gl_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_a_flat(rd_a_flat),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  typedef struct {
    int    exp_a;
    int    exp_b;
    int    exp_flat;
    string tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;

  int unsigned ref_mem [DEPTH];
  int mc = 0;
  int mg = 0;

  function automatic int flat_of(int a, int c, int g);
    int fr = a >> 3;
    int off = a & 7;
    int s = ((NWIN - c) % NWIN) * 2;
    case (fr)
      0:       return g * 8 + off;
      1:       return NGLB * 8 + s * 8 + off;
      2:       return NGLB * 8 + (s + 1) * 8 + off;
      default: return NGLB * 8 + ((s + 2) % (2 * NWIN)) * 8 + off;
    endcase
  endfunction

  function automatic int val_of(int a);
    if (a == 0) return 0;
    return int'(ref_mem[flat_of(a, mc, mg)]);
  endfunction

  task automatic cyc(bit we, int wa, int wd, int c, int g, bit cl,
                     int ra, int rb, string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = wa[4:0]; wr_data = wd;
    cwp_in = c[2:0]; gl_in = g[1:0]; clr = cl;
    rd_a_addr = ra[4:0]; rd_b_addr = rb[4:0];
    it.exp_a = val_of(ra);
    it.exp_b = val_of(rb);
    it.exp_flat = flat_of(ra, mc, mg);
    it.tag = tag;
    q.push_back(it);
    if (cl) begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    end else if (we && wa != 0) begin
      ref_mem[flat_of(wa, mc, mg)] = wd;
    end
    if (c < NWIN) mc = c;
    if (g < NGLB) mg = g;
  endtask

  task automatic rd(int ra, int rb, string tag);
    cyc(0, 0, 0, mc, mg, 0, ra, rb, tag);
  endtask

  task automatic wr(int wa, int wd);
    cyc(1, wa, wd, mc, mg, 0, 0, 0, "R5 idle");
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        n_vec++;
        if (int'(rd_a_data) != it.exp_a) begin
          n_bad++;
          $display("FAIL %s port A data actual %0h expected %0h", it.tag, rd_a_data, it.exp_a);
        end
        if (int'(rd_b_data) != it.exp_b) begin
          n_bad++;
          $display("FAIL %s port B data actual %0h expected %0h", it.tag, rd_b_data, it.exp_b);
        end
        if (int'(rd_a_flat) != it.exp_flat) begin
          n_bad++;
          $display("FAIL %s flat index actual %0d expected %0d", it.tag, rd_a_flat, it.exp_flat);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state, pointer 0 maps outs to the first segment
    rd(8, 0, "R11");
    // R2: ins under pointer 0 sit in segment 2
    rd(29, 18, "R2");
    // R3 / R8: write an out, then change pointer while reading (old mapping)
    wr(9, 'hA1);
    cyc(0, 0, 0, 1, mg, 0, 25, 9, "R8 old mapping");
    rd(25, 9, "R3");
    rd(31, 16, "R2 ins wrap");
    // R2: locals of different windows are distinct
    wr(20, 'hB4);
    cyc(0, 0, 0, 0, mg, 0, 20, 20, "R8 old mapping locals");
    rd(20, 12, "R2 locals");
    // R4 / R1: global banks
    wr(3, 'h33);
    cyc(0, 0, 0, mc, 1, 0, 3, 3, "R8 old level");
    rd(3, 0, "R4");
    wr(3, 'h44);
    rd(3, 3, "R1");
    cyc(0, 0, 0, mc, 0, 0, 3, 0, "R4 switch");
    rd(3, 0, "R4 bank 0 kept");
    // R5: register 0 discards writes
    wr(0, 'hFF);
    rd(0, 0, "R5");
    // R7: read-before-write
    cyc(1, 5, 'h55, mc, mg, 0, 5, 5, "R7");
    rd(5, 5, "R7 after");
    // R9: out-of-range level ignored
    cyc(0, 0, 0, mc, 1, 0, 3, 0, "R9 setup");
    cyc(0, 0, 0, mc, 3, 0, 3, 0, "R9");
    rd(3, 5, "R9 held");
    cyc(0, 0, 0, mc, 0, 0, 0, 0, "R9 back");
    // R8: write with a pointer change uses the old mapping
    cyc(1, 9, 'hC1, 2, mg, 0, 9, 0, "R8 write");
    rd(9, 25, "R8 new window");
    cyc(0, 0, 0, 0, mg, 0, 9, 0, "R8 restore");
    rd(9, 3, "R8 old window");
    // R6: two ports at once
    wr(10, 'h10A);
    wr(11, 'h10B);
    rd(10, 11, "R6");
    rd(11, 10, "R6 swap");
    // R10: clear with a write in the same cycle
    cyc(1, 6, 'h66, mc, mg, 1, 3, 10, "R10 same cycle");
    rd(3, 10, "R10");
    rd(6, 9, "R10 write dropped");
    cyc(0, 0, 0, 1, mg, 0, 0, 0, "R10 move");
    rd(25, 3, "R10 window");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule